// File: doc/BRIEF.md
# Quad Lane Shuffle Unit

This block performs lane exchanges inside quads of a SIMD subgroup. The subgroup is split into groups of four neighbouring lanes, and each group is treated as a 2x2 tile. An issued instruction word is checked for the shuffle category and opcode. A 2-bit variant field in the word then picks one of four patterns: every lane takes the value of a selected lane in its quad, or lanes trade values with their horizontal, vertical or diagonal neighbour in the tile.

Each lane carries a source value and a second operand. Only the broadcast variant reads the second operand, and only its low two bits. The caller also supplies the current destination values and an active-lane mask. Inactive lanes get their current destination value back, so the shuffle never changes them. The result is registered and appears one cycle after issue, together with a valid flag. If either of two reserved bits is set, the word is not executed and a separate illegal-encoding flag is raised instead.

Top module: `quad_xchg_unit`

## Requirements
- R1: While reset is asserted and right after it, `dst_vec` is all zero and `dst_vld` and `bad_enc` are 0.
- R2: An issued word is a shuffle only when bits 63:61 equal 3'b101 and bits 58:53 equal 6'b111111. Any other word leaves `dst_vld` and `bad_enc` at 0 in the next cycle and leaves `dst_vec` unchanged.
- R3: Variant bits 20:19 equal to 2'b00 select broadcast. Each active lane takes the source of lane (quad base + low 2 bits of its own second operand).
- R4: Variant 2'b01 (horizontal swap): each active lane i takes the source of lane i XOR 1.
- R5: Variant 2'b10 (vertical swap): each active lane i takes the source of lane i XOR 2.
- R6: Variant 2'b11 (diagonal swap): each active lane i takes the source of lane i XOR 3.
- R7: Under the three swap variants, the second operand has no effect on the result.
- R8: A lane whose `act_mask` bit is 0 receives its `old_vec` value.
- R9: An active lane that reads from an inactive partner lane gets that partner's source value, unchanged.
- R10: A matching word with bit 18 or bit 50 set raises `bad_enc` for one cycle. In that cycle `dst_vld` stays 0 and `dst_vec` stays unchanged.
- R11: The result of a legal issue appears exactly one cycle later, with `dst_vld` high for that one cycle. Back-to-back issues give back-to-back results.
- R12: A cycle with `issue` low gives `dst_vld` = 0 and leaves `dst_vec` unchanged, whatever the instruction word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word presented this cycle |
| insn | input | 64 | Instruction word |
| src_vec | input | LANES*DW | Per-lane first source values |
| sel_vec | input | LANES*DW | Per-lane second operand (broadcast lane index in low 2 bits) |
| old_vec | input | LANES*DW | Per-lane current destination values |
| act_mask | input | LANES | Active-lane mask |
| dst_vec | output | LANES*DW | Registered per-lane result |
| dst_vld | output | 1 | Result valid, one cycle after a legal issue |
| bad_enc | output | 1 | Reserved bit set in a matching word |

## Verification
Broadcast is driven in three ways: with a different lane index in each lane, with one index shared by all lanes, and with junk in the upper operand bits. These runs show whether each lane reads its own index, and whether only the low two bits count. The three swaps are run on the same distinct lane values, which tells the XOR partners apart. Each swap is then repeated with a changed second operand to show that the operand is ignored. Sparse active masks separate "inactive lane keeps old value" from "inactive partner still supplies its source". Words with a wrong category or opcode, with reserved bits set, or with issue held low confirm that the output is held and that the flags stay separate.

// File: rtl/qx_pkg.sv
package qx_pkg;

    // Field positions in the 64-bit instruction word
    localparam int CAT_HI   = 63;
    localparam int CAT_LO   = 61;
    localparam int OPC_HI   = 58;
    localparam int OPC_LO   = 53;
    localparam int MODE_HI  = 20;
    localparam int MODE_LO  = 19;
    localparam int RSV_LOW  = 18;
    localparam int RSV_HIGH = 50;

    localparam logic [2:0] CAT_CODE = 3'b101;
    localparam logic [5:0] OPC_CODE = 6'b111111;

    typedef enum logic [1:0] {
        QX_BCAST  = 2'b00,
        QX_SWAP_H = 2'b01,
        QX_SWAP_V = 2'b10,
        QX_SWAP_D = 2'b11
    } qx_mode_e;

    typedef struct packed {
        logic     fire;     // legal shuffle issued
        logic     illegal;  // shuffle opcode with reserved bit set
        qx_mode_e mode;
    } qx_dec_t;

    // Source lane within the quad for a given destination lane
    function automatic logic [1:0] qx_partner(input logic [1:0] me,
                                              input qx_mode_e   m,
                                              input logic [1:0] pick);
        logic [1:0] p;
        case (m)
            QX_BCAST:  p = pick;
            QX_SWAP_H: p = me ^ 2'b01;
            QX_SWAP_V: p = me ^ 2'b10;
            default:   p = me ^ 2'b11;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qx_decode.sv
module qx_decode
    import qx_pkg::*;
(
    input  logic        issue,
    input  logic [63:0] insn,
    output qx_dec_t     dec
);
    logic hit;
    logic rsv;

    always_comb begin
        hit         = (insn[CAT_HI:CAT_LO] == CAT_CODE) &&
                      (insn[OPC_HI:OPC_LO] == OPC_CODE);
        rsv         = insn[RSV_LOW] | insn[RSV_HIGH];
        dec.fire    = issue && hit && !rsv;
        dec.illegal = issue && hit && rsv;
        dec.mode    = qx_mode_e'(insn[MODE_HI:MODE_LO]);
    end

    // R10: a word cannot be both executed and flagged
    always_comb begin
        fire_excl_chk: assert (!(dec.fire && dec.illegal));
    end

endmodule

// File: rtl/qx_quad.sv
module qx_quad
    import qx_pkg::*;
#(
    parameter int DW = 16
) (
    input  qx_mode_e          mode,
    input  logic [4*DW-1:0]   src,
    input  logic [4*DW-1:0]   sel,
    input  logic [4*DW-1:0]   old,
    input  logic [3:0]        act,
    output logic [4*DW-1:0]   res
);
    for (genvar l = 0; l < 4; l++) begin : g_lane
        localparam logic [1:0] ME = 2'(l);
        logic [1:0]    pl;
        logic [DW-1:0] pick_val;

        always_comb begin
            pl       = qx_partner(ME, mode, sel[l*DW +: 2]);
            pick_val = src[pl*DW +: DW];
            res[l*DW +: DW] = act[l] ? pick_val : old[l*DW +: DW];
        end
    end

endmodule

// File: rtl/quad_xchg_unit.sv
module quad_xchg_unit
    import qx_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [63:0]           insn,
    input  logic [LANES*DW-1:0]   src_vec,
    input  logic [LANES*DW-1:0]   sel_vec,
    input  logic [LANES*DW-1:0]   old_vec,
    input  logic [LANES-1:0]      act_mask,
    output logic [LANES*DW-1:0]   dst_vec,
    output logic                  dst_vld,
    output logic                  bad_enc
);
    localparam int QUADS = LANES / 4;
    localparam int QW    = 4 * DW;
    localparam int VW    = LANES * DW;

    qx_dec_t       dec;
    logic [VW-1:0] shuf;

    qx_decode u_dec (
        .issue (issue),
        .insn  (insn),
        .dec   (dec)
    );

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        qx_quad #(.DW(DW)) u_quad (
            .mode (dec.mode),
            .src  (src_vec[q*QW +: QW]),
            .sel  (sel_vec[q*QW +: QW]),
            .old  (old_vec[q*QW +: QW]),
            .act  (act_mask[q*4 +: 4]),
            .res  (shuf[q*QW +: QW])
        );
    end

    typedef struct packed {
        logic [VW-1:0] dst;
        logic          vld;
        logic          bad;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.bad = 1'b0;
        if (dec.fire) begin
            st_d.dst = shuf;
            st_d.vld = 1'b1;
        end
        if (dec.illegal) begin
            st_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_vec = st_q.dst;
    assign dst_vld = st_q.vld;
    assign bad_enc = st_q.bad;

    // R11
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.fire |=> dst_vld);

    // R10
    bad_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dst_vld && bad_enc));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_vld |-> $stable(dst_vec));

    // R4
    horiz_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.fire && dec.mode == QX_SWAP_H && act_mask[0])
        |=> (dst_vec[DW-1:0] == $past(src_vec[2*DW-1:DW])));

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        // R8
        inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.fire && !act_mask[i])
            |=> (dst_vec[i*DW +: DW] == $past(old_vec[i*DW +: DW])));
    end

endmodule

// File: tb/tb_quad_xchg_unit.sv
`timescale 1ns/1ps
module tb_quad_xchg_unit;
    localparam int LANES = 16;
    localparam int DW    = 16;
    localparam int VW    = LANES * DW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue = 1'b0;
    logic [63:0]     insn = '0;
    logic [VW-1:0]   src_vec = '0;
    logic [VW-1:0]   sel_vec = '0;
    logic [VW-1:0]   old_vec = '0;
    logic [LANES-1:0] act_mask = '0;
    logic [VW-1:0]   dst_vec;
    logic            dst_vld;
    logic            bad_enc;

    always #10 clk = ~clk;

    quad_xchg_unit #(.LANES(LANES), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
        .src_vec(src_vec), .sel_vec(sel_vec), .old_vec(old_vec),
        .act_mask(act_mask), .dst_vec(dst_vec), .dst_vld(dst_vld),
        .bad_enc(bad_enc)
    );

    typedef struct {
        logic          vld;
        logic          bad;
        logic [VW-1:0] dst;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    logic [VW-1:0] model_dst = '0;
    bit            done = 0;

    function automatic logic [63:0] mk(input logic [2:0] cat, input logic [5:0] opc,
                                       input logic [1:0] v, input logic r18,
                                       input logic r50);
        logic [63:0] w;
        w = 64'h0000_1234_0000_0000;
        w[17:0]  = 18'h2a5a5;
        w[63:61] = cat;
        w[58:53] = opc;
        w[20:19] = v;
        w[18]    = r18;
        w[50]    = r50;
        return w;
    endfunction

    function automatic logic [VW-1:0] ref_calc(input logic [1:0] v,
            input logic [VW-1:0] s, input logic [VW-1:0] x,
            input logic [VW-1:0] o, input logic [LANES-1:0] a);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            int p;
            case (v)
                2'd0: p = (i / 4) * 4 + int'(x[i*DW +: 2]);
                2'd1: p = i ^ 1;
                2'd2: p = i ^ 2;
                default: p = i ^ 3;
            endcase
            r[i*DW +: DW] = a[i] ? s[p*DW +: DW] : o[i*DW +: DW];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*DW +: DW] = DW'($urandom);
        return r;
    endfunction

    function automatic logic [VW-1:0] lane_ids(input int base);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*DW +: DW] = DW'(base + i);
        return r;
    endfunction

    task automatic drive(input logic is, input logic [63:0] w,
                         input logic [VW-1:0] s, input logic [VW-1:0] x,
                         input logic [VW-1:0] o, input logic [LANES-1:0] a,
                         input string tag);
        exp_t e;
        logic hit, ill;
        @(negedge clk);
        issue = is; insn = w; src_vec = s; sel_vec = x; old_vec = o; act_mask = a;
        hit = (w[63:61] == 3'b101) && (w[58:53] == 6'b111111);
        ill = w[18] | w[50];
        e.vld = 1'b0; e.bad = 1'b0; e.tag = tag;
        if (is && hit && !ill) begin
            model_dst = ref_calc(w[20:19], s, x, o, a);
            e.vld = 1'b1;
        end else if (is && hit) begin
            e.bad = 1'b1;
        end
        e.dst = model_dst;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (dst_vld !== e.vld || bad_enc !== e.bad || dst_vec !== e.dst) begin
                    n_bad++;
                    $display("FAIL %s: vld=%b bad=%b dst=%h expected vld=%b bad=%b dst=%h",
                             e.tag, dst_vld, bad_enc, dst_vec, e.vld, e.bad, e.dst);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] s, x, o, x2;
        logic [63:0] ok_b, ok_h, ok_v, ok_d;
        ok_b = mk(3'b101, 6'h3f, 2'b00, 1'b0, 1'b0);
        ok_h = mk(3'b101, 6'h3f, 2'b01, 1'b0, 1'b0);
        ok_v = mk(3'b101, 6'h3f, 2'b10, 1'b0, 1'b0);
        ok_d = mk(3'b101, 6'h3f, 2'b11, 1'b0, 1'b0);

        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        n_chk++;
        if (dst_vec !== '0 || dst_vld !== 1'b0 || bad_enc !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: vld=%b bad=%b dst=%h expected all zero", dst_vld, bad_enc, dst_vec);
        end
        @(negedge clk);
        rst_n = 1'b1;

        s = lane_ids(16'h100);
        o = lane_ids(16'hd00);
        // R3: per-lane broadcast index
        x = '0;
        for (int i = 0; i < LANES; i++) x[i*DW +: DW] = DW'((i * 3 + 1) % 4);
        drive(1, ok_b, s, x, o, '1, "R3");
        // R3: shared index 3, junk in upper operand bits
        for (int i = 0; i < LANES; i++) x[i*DW +: DW] = 16'hfff3;
        drive(1, ok_b, s, x, o, '1, "R3");
        // R4 / R5 / R6: swaps
        drive(1, ok_h, s, '0, o, '1, "R4");
        drive(1, ok_v, s, '0, o, '1, "R5");
        drive(1, ok_d, s, '0, o, '1, "R6");
        // R7: swaps with a different second operand
        x2 = rnd_vec();
        drive(1, ok_h, s, x2, o, '1, "R7");
        drive(1, ok_v, s, x2, o, '1, "R7");
        drive(1, ok_d, s, x2, o, '1, "R7");
        // R8: inactive lanes keep old value
        drive(1, ok_d, s, '0, o, 16'b0101_1010_0000_1111, "R8");
        // R9: active lane with inactive partner gets partner source
        drive(1, ok_h, s, '0, o, 16'b0001_0010_0100_1000, "R9");
        x = '0;
        x[0 +: DW] = 16'd2;
        drive(1, ok_b, s, x, o, 16'b0000_0000_0000_0001, "R9");
        // R10: reserved bits
        drive(1, mk(3'b101, 6'h3f, 2'b01, 1'b1, 1'b0), rnd_vec(), '0, o, '1, "R10");
        drive(1, mk(3'b101, 6'h3f, 2'b10, 1'b0, 1'b1), rnd_vec(), '0, o, '1, "R10");
        // R2: wrong category / wrong opcode
        drive(1, mk(3'b100, 6'h3f, 2'b01, 1'b0, 1'b0), rnd_vec(), '0, o, '1, "R2");
        drive(1, mk(3'b101, 6'h3e, 2'b01, 1'b0, 1'b0), rnd_vec(), '0, o, '1, "R2");
        drive(1, mk(3'b101, 6'h1f, 2'b00, 1'b1, 1'b0), rnd_vec(), '0, o, '1, "R2");
        // R12: issue low with a legal word
        drive(0, ok_d, rnd_vec(), '0, o, '1, "R12");
        drive(0, ok_b, rnd_vec(), rnd_vec(), rnd_vec(), '1, "R12");
        // R11: back-to-back issues then idle
        drive(1, ok_h, rnd_vec(), '0, rnd_vec(), '1, "R11");
        drive(1, ok_v, rnd_vec(), '0, rnd_vec(), '1, "R11");
        drive(1, ok_b, rnd_vec(), rnd_vec(), rnd_vec(), '1, "R11");
        drive(0, '0, rnd_vec(), '0, o, '1, "R11");
        // mixed pseudo-random traffic
        for (int k = 0; k < 60; k++) begin
            logic [1:0] v;
            v = 2'($urandom);
            drive(1'($urandom), mk(3'b101, 6'h3f, v, ($urandom % 8) == 0, 1'b0),
                  rnd_vec(), rnd_vec(), rnd_vec(), LANES'($urandom),
                  (v == 2'd0) ? "R3" : (v == 2'd1) ? "R4" : (v == 2'd2) ? "R5" : "R6");
        end
        drive(0, '0, '0, '0, '0, '0, "R12");
        repeat (3) @(posedge clk);
        #6;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule